// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block watches the health of a 10 Mb/s twisted-pair port. An analog front end qualifies amplitude and width and hands the block single-cycle strobes: one for a positive link pulse, one for a negative link pulse, and a level for receive data activity. From these the block keeps a two-state machine. `ST_LINK_FAIL` is entered at reset, on a switch onto the twisted-pair port and on a link-loss timeout. `ST_LINK_PASS` is entered from fail on receive data or on a run of same-polarity link pulses.

While the link is failed, the transmit, receive, loopback and collision paths are held off. A transmit request made in that state raises loss-of-carrier and collision-error flags and sends nothing to the line. When the link passes, the polarity of the qualifying pulse run is presented as the receive inversion setting. From then on, only pulses of that polarity keep the link alive. A link-test-disable input forces all path enables on, whatever the state. An idle link-pulse strobe is produced periodically and is held back while a frame is being sent.

Transitions: FAIL→PASS on receive data (`T_DATA`) or a completed pulse run (`T_RUN`). PASS→FAIL on a port switch (`T_PORT`) or a timeout (`T_LOSS`). FAIL→FAIL on a port switch clears the run.

Top module: `tp_link_monitor`

## Requirements
- R1: After reset the monitor is in `ST_LINK_FAIL`. In that state `link_ok_o`=0, all four enables are 0 (with link test enabled), `rx_pol_inv_o`=0, both error flags are 0 and `idle_pulse_o`=0.
- R2: In fail, `RUN_LEN` consecutive single-polarity pulses move the monitor to pass on the edge that samples the last pulse. On the same edge `rx_pol_inv_o` takes the run polarity: 1 for negative, 0 for positive.
- R3: In fail, a pulse whose polarity differs from the run so far restarts the run with a count of one. A cycle with both strobes high is not a pulse and changes nothing.
- R4: In fail, `rx_data_i` high moves the monitor to pass on the next edge. This takes priority over a run completing in the same cycle, and `rx_pol_inv_o` is left unchanged.
- R5: Each of `tx_en_o`, `rx_en_o`, `lb_en_o` and `col_en_o` equals `lt_disable_i` OR (state is pass).
- R6: With link test enabled, a `tx_req_i` sampled in fail sets `lcar_err_o` and `col_err_o` to 1 for the following cycle. Otherwise both are 0.
- R7: `port_sel_tp_i` forces fail on the next edge from either state and clears any run in progress. It takes priority over everything else.
- R8: In pass, only a pulse of the locked polarity, or receive data, restarts the link-loss timer. A pulse of the other polarity has no effect.
- R9: In pass, `LOSS_CYCLES` consecutive cycles without a restart event return the monitor to fail.
- R10: `idle_pulse_o` is high for one cycle every `IDLE_CYCLES` cycles, regardless of link state or link-test disable. A cycle with `tx_req_i` and `tx_en_o` both high resets the interval and suppresses the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_pos_i | input | 1 | Qualified positive link pulse strobe |
| lp_neg_i | input | 1 | Qualified negative link pulse strobe |
| rx_data_i | input | 1 | Valid receive data present |
| lt_disable_i | input | 1 | Link test disable: forces path enables on |
| port_sel_tp_i | input | 1 | Strobe: port selection switched onto twisted pair |
| tx_req_i | input | 1 | Transmit request / transmission in progress |
| link_ok_o | output | 1 | Link status (1 in pass) |
| tx_en_o | output | 1 | Transmit path enable |
| rx_en_o | output | 1 | Receive path enable |
| lb_en_o | output | 1 | Loopback path enable |
| col_en_o | output | 1 | Collision detect enable |
| lcar_err_o | output | 1 | Loss-of-carrier error for transmit in fail |
| col_err_o | output | 1 | Collision error for transmit in fail |
| rx_pol_inv_o | output | 1 | Receive polarity inversion (1 = negative) |
| idle_pulse_o | output | 1 | Idle link pulse transmit strobe |

## Verification
State, polarity, error flags and the idle strobe are registered, so each is due one clock after the input cycle that causes it. The enables are combinational from the state register and `lt_disable_i`, so they follow the state one clock after a transition and follow the disable input within the same cycle. The bench drives inputs on the falling edge and advances its reference model by one step per rising edge. It compares every output on the next falling edge while the inputs of that step are still held, so no result is sampled early or late.

// File: rtl/tp_link_pkg.sv
package tp_link_pkg;
    typedef enum logic {
        ST_LINK_FAIL = 1'b0,
        ST_LINK_PASS = 1'b1
    } link_state_t;
endpackage

// File: rtl/tp_run_qualifier.sv
module tp_run_qualifier #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic pos_i,
    input  logic neg_i,
    output logic done_o,
    output logic done_pol_o
);
    localparam int CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;
    logic          last_q;
    logic          single;
    logic          pol;
    logic          same;

    always_comb begin
        single     = pos_i ^ neg_i;
        pol        = neg_i;
        same       = (cnt_q == '0) || (last_q == pol);
        cnt_nx     = same ? cnt_q + CW'(1) : CW'(1);
        done_o     = single && (cnt_nx == CW'(RUN_LEN));
        done_pol_o = pol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= 1'b0;
        end else if (clr_i || done_o) begin
            cnt_q  <= '0;
        end else if (single) begin
            cnt_q  <= cnt_nx;
            last_q <= pol;
        end
    end

    // R3
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(RUN_LEN));
endmodule

// File: rtl/tp_loss_timer.sv
module tp_loss_timer #(
    parameter int LOSS_CYCLES = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic kick_i,
    output logic expired_o
);
    localparam int LW = $clog2(LOSS_CYCLES);

    logic [LW-1:0] cnt_q;

    assign expired_o = run_i && !kick_i && (cnt_q == LW'(LOSS_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i || kick_i || expired_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + LW'(1);
    end

    // R9
    loss_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LW'(LOSS_CYCLES - 1));
endmodule

// File: rtl/tp_idle_pulse_gen.sv
module tp_idle_pulse_gen #(
    parameter int IDLE_CYCLES = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    output logic pulse_o
);
    localparam int IW = $clog2(IDLE_CYCLES);

    logic [IW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_o <= 1'b0;
        end else if (hold_i) begin
            cnt_q   <= '0;
            pulse_o <= 1'b0;
        end else if (cnt_q == IW'(IDLE_CYCLES - 1)) begin
            cnt_q   <= '0;
            pulse_o <= 1'b1;
        end else begin
            cnt_q   <= cnt_q + IW'(1);
            pulse_o <= 1'b0;
        end
    end

    // R10
    idle_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> !pulse_o);
endmodule

// File: rtl/tp_link_monitor.sv
module tp_link_monitor
    import tp_link_pkg::*;
#(
    parameter int RUN_LEN     = 5,
    parameter int LOSS_CYCLES = 12_500_000,
    parameter int IDLE_CYCLES = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_pos_i,
    input  logic lp_neg_i,
    input  logic rx_data_i,
    input  logic lt_disable_i,
    input  logic port_sel_tp_i,
    input  logic tx_req_i,
    output logic link_ok_o,
    output logic tx_en_o,
    output logic rx_en_o,
    output logic lb_en_o,
    output logic col_en_o,
    output logic lcar_err_o,
    output logic col_err_o,
    output logic rx_pol_inv_o,
    output logic idle_pulse_o
);
    link_state_t state_q, state_nx;
    logic        pol_q;
    logic        err_q;
    logic        run_done;
    logic        run_pol;
    logic        loss_exp;
    logic        valid_pulse;
    logic        path_en;

    tp_run_qualifier #(.RUN_LEN(RUN_LEN)) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      ((state_q != ST_LINK_FAIL) || port_sel_tp_i),
        .pos_i      (lp_pos_i),
        .neg_i      (lp_neg_i),
        .done_o     (run_done),
        .done_pol_o (run_pol)
    );

    assign valid_pulse = pol_q ? (lp_neg_i && !lp_pos_i) : (lp_pos_i && !lp_neg_i);

    tp_loss_timer #(.LOSS_CYCLES(LOSS_CYCLES)) u_loss (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (state_q == ST_LINK_PASS),
        .kick_i    (valid_pulse || rx_data_i),
        .expired_o (loss_exp)
    );

    tp_idle_pulse_gen #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_i  (tx_req_i && tx_en_o),
        .pulse_o (idle_pulse_o)
    );

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_LINK_FAIL: begin
                if (!port_sel_tp_i && (rx_data_i || run_done))
                    state_nx = ST_LINK_PASS;
            end
            ST_LINK_PASS: begin
                if (port_sel_tp_i || loss_exp)
                    state_nx = ST_LINK_FAIL;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LINK_FAIL;
            pol_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_nx;
            err_q   <= tx_req_i && (state_q == ST_LINK_FAIL) && !lt_disable_i;
            if ((state_q == ST_LINK_FAIL) && !port_sel_tp_i && !rx_data_i && run_done)
                pol_q <= run_pol;
        end
    end

    always_comb begin
        path_en      = lt_disable_i || (state_q == ST_LINK_PASS);
        link_ok_o    = (state_q == ST_LINK_PASS);
        tx_en_o      = path_en;
        rx_en_o      = path_en;
        lb_en_o      = path_en;
        col_en_o     = path_en;
        lcar_err_o   = err_q;
        col_err_o    = err_q;
        rx_pol_inv_o = pol_q;
    end

    // R7
    port_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_sel_tp_i |=> !link_ok_o);
    // R6
    tx_fail_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req_i && !link_ok_o && !lt_disable_i) |=> (lcar_err_o && col_err_o));
    // R2
    pass_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_ok_o) |-> $past(rx_data_i || lp_pos_i || lp_neg_i));
    // R4
    pol_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_ok_o |=> $stable(rx_pol_inv_o));
endmodule

// File: tb/tb_tp_link_monitor.sv
module tb_tp_link_monitor;
    localparam int RUN  = 5;
    localparam int LOSS = 300;
    localparam int IDLE = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic p = 0, n = 0, d = 0, dis = 0, ps = 0, tx = 0;
    logic link_ok, tx_en, rx_en, lb_en, col_en, lcar, colerr, pol, idle;

    int checks = 0;
    int failures = 0;

    bit m_pass, m_last, m_pol, m_err, m_idlep;
    int m_cnt, m_loss, m_idle;

    always #4 clk = ~clk;

    tp_link_monitor #(.RUN_LEN(RUN), .LOSS_CYCLES(LOSS), .IDLE_CYCLES(IDLE)) dut (
        .clk(clk), .rst_n(rst_n), .lp_pos_i(p), .lp_neg_i(n), .rx_data_i(d),
        .lt_disable_i(dis), .port_sel_tp_i(ps), .tx_req_i(tx),
        .link_ok_o(link_ok), .tx_en_o(tx_en), .rx_en_o(rx_en), .lb_en_o(lb_en),
        .col_en_o(col_en), .lcar_err_o(lcar), .col_err_o(colerr),
        .rx_pol_inv_o(pol), .idle_pulse_o(idle)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_en();
        return dis | m_pass;
    endfunction

    task automatic model_step();
        bit txen_b, single, pv, valid;
        txen_b = dis | m_pass;
        m_err  = tx && !m_pass && !dis;
        if (tx && txen_b) begin m_idle = 0; m_idlep = 0; end
        else if (m_idle == IDLE - 1) begin m_idle = 0; m_idlep = 1; end
        else begin m_idle++; m_idlep = 0; end
        single = p ^ n;
        pv = n;
        if (!m_pass) begin
            if (ps) m_cnt = 0;
            else if (d) begin m_pass = 1; m_cnt = 0; m_loss = 0; end
            else if (single) begin
                if (m_cnt != 0 && pv != m_last) m_cnt = 1;
                else m_cnt++;
                m_last = pv;
                if (m_cnt == RUN) begin m_pass = 1; m_pol = pv; m_cnt = 0; m_loss = 0; end
            end
        end else begin
            valid = m_pol ? (n && !p) : (p && !n);
            if (ps) begin m_pass = 0; m_cnt = 0; end
            else if (valid || d) m_loss = 0;
            else if (m_loss == LOSS - 1) begin m_pass = 0; m_loss = 0; m_cnt = 0; end
            else m_loss++;
        end
    endtask

    task automatic compare_all();
        chk("R2 link_ok", link_ok, m_pass);
        chk("R5 tx_en", tx_en, exp_en());
        chk("R5 rx_en", rx_en, exp_en());
        chk("R5 lb_en", lb_en, exp_en());
        chk("R5 col_en", col_en, exp_en());
        chk("R6 lcar_err", lcar, m_err);
        chk("R6 col_err", colerr, m_err);
        chk("R8 rx_pol_inv", pol, m_pol);
        chk("R10 idle_pulse", idle, m_idlep);
    endtask

    // one cycle: drive at falling edge, step on rising edge, check at next falling edge
    task automatic cyc(input logic ip, input logic in_, input logic id,
                       input logic idis, input logic ips, input logic itx);
        p = ip; n = in_; d = id; dis = idis; ps = ips; tx = itx;
        @(posedge clk);
        @(negedge clk);
        model_step();
        compare_all();
    endtask

    task automatic idle_cycles(input int k);
        for (int i = 0; i < k; i++) cyc(0, 0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        m_pass = 0; m_last = 0; m_pol = 0; m_err = 0; m_idlep = 0;
        m_cnt = 0; m_loss = 0; m_idle = 0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 link_ok", link_ok, 0);
        chk("R1 tx_en", tx_en, 0);
        chk("R1 col_en", col_en, 0);
        chk("R1 pol", pol, 0);
        chk("R1 err", lcar, 0);
        chk("R1 idle", idle, 0);
        rst_n = 1'b1;
        @(negedge clk);
        model_step();
        compare_all();

        // R6 transmit while failed
        cyc(0, 0, 0, 0, 0, 1);
        chk("R6 lcar directed", lcar, 1);
        chk("R6 tx_en off", tx_en, 0);
        // R3: run broken by opposite polarity, both-high ignored
        cyc(1, 0, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R3 both-high ignored", link_ok, 0);
        cyc(0, 1, 0, 0, 0, 0);
        for (int i = 0; i < RUN - 2; i++) cyc(0, 1, 0, 0, 0, 0);
        chk("R3 restarted run not done", link_ok, 0);
        // R2 negative run completes
        cyc(0, 1, 0, 0, 0, 0);
        chk("R2 pass after neg run", link_ok, 1);
        chk("R2 pol negative", pol, 1);
        // R8 positive pulses do not keep link alive
        for (int i = 0; i < LOSS - 2; i++) cyc((i % 10) == 0, 0, 0, 0, 0, 0);
        chk("R8 still pass", link_ok, 1);
        idle_cycles(4);
        chk("R9 timeout fail", link_ok, 0);
        // R5 link test disable forces enables
        cyc(0, 0, 0, 1, 0, 1);
        chk("R5 disable enables", tx_en, 1);
        chk("R5 disable col_en", col_en, 1);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R6 no err when disabled", lcar, 0);
        // R4 data entry, R7 port switch
        cyc(0, 0, 1, 0, 0, 0);
        chk("R4 pass on data", link_ok, 1);
        chk("R4 pol kept", pol, 1);
        cyc(0, 0, 0, 0, 1, 0);
        chk("R7 port switch fail", link_ok, 0);
        cyc(1, 0, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0);
        for (int i = 0; i < RUN - 1; i++) cyc(1, 0, 0, 0, 0, 0);
        chk("R7 run cleared", link_ok, 0);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R2 pass after pos run", link_ok, 1);
        chk("R2 pol positive", pol, 0);
        // R10 idle strobe suppressed by transmission
        for (int i = 0; i < 3 * IDLE; i++) cyc(0, 0, 1, 0, 0, 1);
        chk("R10 suppressed", idle, 0);

        // constrained random segments
        for (int s = 0; s < 40; s++) begin
            int pr, negb, quiet;
            pr    = ($urandom % 3 == 0) ? 1000 : 6 + $urandom % 20;
            negb  = $urandom % 100;
            quiet = $urandom % 2;
            for (int c = 0; c < 120; c++) begin
                bit rp, rn, rd, rdis, rps, rtx;
                rp = 0; rn = 0;
                if ($urandom % pr == 0) begin
                    if ($urandom % 40 == 0) begin rp = 1; rn = 1; end
                    else if (($urandom % 100) < negb) rn = 1;
                    else rp = 1;
                end
                rd   = !quiet && ($urandom % 90 == 0);
                rdis = (s % 7 == 3);
                rps  = ($urandom % 250 == 0);
                rtx  = ($urandom % 5 == 0);
                cyc(rp, rn, rd, rdis, rps, rtx);
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule